// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the clock and data lines of an SMBus segment, together with a local indication that this node is currently holding the clock low, and raises a single sticky timeout flag when a programmed timing limit is broken. The line levels are resynchronized to the kernel clock before any checker sees them.

Two checkers share the flag and have separate enables. The first holds a 12-bit limit and a mode bit. In clock-low mode it measures how long SCL has been continuously low, in units of 2048 kernel cycles. In bus-idle mode it measures how long SCL and SDA have both been continuously high, in units of 4 kernel cycles. The second checker holds its own 12-bit limit. It adds up the cycles in which this node stretches the clock, and the start and stop events of the bus clear that sum. One such limit covers both the master-side and the slave-side extended-low budget, because the bus rules give only an upper bound for each.

Software loads each checker's limit with a write strobe while that checker is disabled, then enables it. The flag stays high until a clear strobe arrives.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: With checker A enabled in clock-low mode (mode bit 0), the flag rises when SCL has been low for (limitA+1)*2048 cycles. After SCL falls at a driven edge, the flag is still 0 after edge 2049 and is 1 after edge 2050 for limitA = 0, because of the two-stage synchronizer.
- R2: With checker A enabled in bus-idle mode (mode bit 1), the flag rises after SCL and SDA have both been high for (limitA+1)*4 synchronized cycles.
- R3: Checker A's count restarts from zero whenever its condition breaks: SCL high in clock-low mode, or either line low in bus-idle mode.
- R4: Checker B counts only the cycles in which stretchAct is 1. The count holds while stretchAct is 0, and the flag rises once the total reaches (limitB+1)*2048.
- R5: A startEvt or stopEvt pulse resets checker B's accumulated count to zero.
- R6: The flag stays 1 until flagClr is pulsed, and is 0 on the cycle after the clear. When a timeout and a clear arrive in the same cycle, the flag stays set.
- R7: Deasserting a checker's enable resets that checker's count and leaves the flag unchanged.
- R8: cfgWrA is ignored while enA is 1, and cfgWrB is ignored while enB is 1. The stored limit and mode keep their previous values.
- R9: After reset the flag is 0, both limits are 0 and the mode is clock-low. While both enables are 0, no line activity or stretching sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| stretchAct | input | 1 | This node is holding SCL low (kernel-clock domain) |
| startEvt | input | 1 | Start condition seen, one-cycle pulse |
| stopEvt | input | 1 | Stop condition seen, one-cycle pulse |
| cfgWrA | input | 1 | Write strobe for the checker A limit and mode |
| cfgLimitA | input | 12 | Checker A limit value |
| cfgIdleA | input | 1 | Checker A mode: 0 clock-low, 1 bus-idle |
| cfgWrB | input | 1 | Write strobe for the checker B limit |
| cfgLimitB | input | 12 | Checker B limit value |
| enA | input | 1 | Checker A enable |
| enB | input | 1 | Checker B enable |
| flagClr | input | 1 | Clears the timeout flag |
| timeoutFlag | output | 1 | Sticky timeout flag |

## Verification
The hardest situation to reach from the ports is a checker B total that is split across several stretch intervals. The flag then depends on cycles added up over gaps, and a transfer-boundary event can silently zero the total. The stimulus stretches for 3000 cycles, pauses, optionally pulses a start or stop event, and stretches again. The expected flag edge is computed for both the carried-over total and the reset total, so a count that fails to hold or fails to clear moves the edge by more than a thousand cycles. The frozen-configuration rule is reached the same way: the bench writes a limit that would fire sooner while the checker runs, and shows that the edge does not move.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic armA;     // checker A running
    logic idleA;    // checker A bus-idle mode
    logic armB;     // checker B running
    logic xferRst;  // start or stop condition seen
  } ctlStrobes_t;
endpackage

// File: rtl/smbto_sync.sv
module smbto_sync #(
  parameter int   WIDTH     = 2,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= {STAGES{{WIDTH{RESET_VAL}}}};
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/smbto_window.sv
module smbto_window #(
  parameter int LIMIT_W = 12,
  parameter int DIV_W   = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               clear,
  input  logic [DIV_W-1:0]   divLast,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  logic [DIV_W-1:0]   pre;
  logic [LIMIT_W-1:0] cnt;
  logic               tick;

  assign tick   = run && (pre == divLast);
  assign expire = tick && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
    end else if (clear || expire) begin
      pre <= '0;
      cnt <= '0;
    end else if (run) begin
      if (tick) begin
        pre <= '0;
        cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit); // R1
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (cnt == '0) && (pre == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !clear) |=> $stable(cnt) && $stable(pre)); // R4
endmodule

// File: rtl/smbto_ctrl.sv
module smbto_ctrl
  import smbto_pkg::*;
#(
  parameter int LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrA,
  input  logic [LIMIT_W-1:0] cfgLimitA,
  input  logic               cfgIdleA,
  input  logic               cfgWrB,
  input  logic [LIMIT_W-1:0] cfgLimitB,
  input  logic               enA,
  input  logic               enB,
  input  logic               startEvt,
  input  logic               stopEvt,
  input  logic               flagClr,
  input  logic               expireA,
  input  logic               expireB,
  output ctlStrobes_t        ctl,
  output logic [LIMIT_W-1:0] limitA,
  output logic [LIMIT_W-1:0] limitB,
  output logic               timeoutFlag
);
  logic idleReg;

  // configuration only accepted while the matching checker is stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitA  <= '0;
      idleReg <= 1'b0;
      limitB  <= '0;
    end else begin
      if (cfgWrA && !enA) begin
        limitA  <= cfgLimitA;
        idleReg <= cfgIdleA;
      end
      if (cfgWrB && !enB) limitB <= cfgLimitB;
    end
  end

  // sticky flag, a new timeout wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeoutFlag <= 1'b0;
    else       timeoutFlag <= (timeoutFlag && !flagClr) || expireA || expireB;
  end

  always_comb begin
    ctl.armA    = enA;
    ctl.idleA   = idleReg;
    ctl.armB    = enB;
    ctl.xferRst = startEvt || stopEvt;
  end

  AST_CFG_A_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    enA |=> $stable(limitA) && $stable(idleReg)); // R8
  AST_CFG_B_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    enB |=> $stable(limitB)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag); // R6
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(expireA || expireB)); // R1
endmodule

// File: rtl/smbto_datapath.sv
module smbto_datapath
  import smbto_pkg::*;
#(
  parameter int LIMIT_W   = 12,
  parameter int LONG_DIV  = 2048,
  parameter int SHORT_DIV = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               stretchAct,
  input  ctlStrobes_t        ctl,
  input  logic [LIMIT_W-1:0] limitA,
  input  logic [LIMIT_W-1:0] limitB,
  output logic               expireA,
  output logic               expireB
);
  localparam int DIV_W = (LONG_DIV > 2) ? $clog2(LONG_DIV) : 2;
  localparam logic [DIV_W-1:0] LONG_LAST  = DIV_W'(LONG_DIV - 1);
  localparam logic [DIV_W-1:0] SHORT_LAST = DIV_W'(SHORT_DIV - 1);

  logic [1:0]       lineSync;
  logic             sclS;
  logic             sdaS;
  logic             condA;
  logic [DIV_W-1:0] divLastA;

  smbto_sync #(.WIDTH(2), .STAGES(SYNC_LEN), .RESET_VAL(1'b1)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout (lineSync)
  );
  assign sclS = lineSync[1];
  assign sdaS = lineSync[0];

  always_comb begin
    condA    = ctl.idleA ? (sclS && sdaS) : !sclS;
    divLastA = ctl.idleA ? SHORT_LAST : LONG_LAST;
  end

  smbto_window #(.LIMIT_W(LIMIT_W), .DIV_W(DIV_W)) uWinA (
    .clk     (clk),
    .rstN    (rstN),
    .run     (ctl.armA && condA),
    .clear   (!ctl.armA || !condA),
    .divLast (divLastA),
    .limit   (limitA),
    .expire  (expireA)
  );

  smbto_window #(.LIMIT_W(LIMIT_W), .DIV_W(DIV_W)) uWinB (
    .clk     (clk),
    .rstN    (rstN),
    .run     (ctl.armB && stretchAct && !ctl.xferRst),
    .clear   (!ctl.armB || ctl.xferRst),
    .divLast (LONG_LAST),
    .limit   (limitB),
    .expire  (expireB)
  );

  AST_A_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.armA |=> !expireA); // R7
  AST_B_QUIET_RST: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xferRst |=> !expireB); // R5
endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
  import smbto_pkg::*;
#(
  parameter int LIMIT_W   = 12,
  parameter int LONG_DIV  = 2048,
  parameter int SHORT_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               stretchAct,
  input  logic               startEvt,
  input  logic               stopEvt,
  input  logic               cfgWrA,
  input  logic [LIMIT_W-1:0] cfgLimitA,
  input  logic               cfgIdleA,
  input  logic               cfgWrB,
  input  logic [LIMIT_W-1:0] cfgLimitB,
  input  logic               enA,
  input  logic               enB,
  input  logic               flagClr,
  output logic               timeoutFlag
);
  ctlStrobes_t        ctl;
  logic [LIMIT_W-1:0] limitA;
  logic [LIMIT_W-1:0] limitB;
  logic               expireA;
  logic               expireB;

  smbto_ctrl #(.LIMIT_W(LIMIT_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrA      (cfgWrA),
    .cfgLimitA   (cfgLimitA),
    .cfgIdleA    (cfgIdleA),
    .cfgWrB      (cfgWrB),
    .cfgLimitB   (cfgLimitB),
    .enA         (enA),
    .enB         (enB),
    .startEvt    (startEvt),
    .stopEvt     (stopEvt),
    .flagClr     (flagClr),
    .expireA     (expireA),
    .expireB     (expireB),
    .ctl         (ctl),
    .limitA      (limitA),
    .limitB      (limitB),
    .timeoutFlag (timeoutFlag)
  );

  smbto_datapath #(
    .LIMIT_W   (LIMIT_W),
    .LONG_DIV  (LONG_DIV),
    .SHORT_DIV (SHORT_DIV),
    .SYNC_LEN  (2)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .stretchAct (stretchAct),
    .ctl        (ctl),
    .limitA     (limitA),
    .limitB     (limitB),
    .expireA    (expireA),
    .expireB    (expireB)
  );
endmodule

// File: tb/test_smbus_timeout_monitor.sv
`timescale 1ns/100ps
module test_smbus_timeout_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic        stretchAct = 1'b0;
  logic        startEvt = 1'b0;
  logic        stopEvt = 1'b0;
  logic        cfgWrA = 1'b0;
  logic [11:0] cfgLimitA = '0;
  logic        cfgIdleA = 1'b0;
  logic        cfgWrB = 1'b0;
  logic [11:0] cfgLimitB = '0;
  logic        enA = 1'b0;
  logic        enB = 1'b0;
  logic        flagClr = 1'b0;
  logic        timeoutFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    val;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  smbus_timeout_monitor i_smbus_timeout_monitor (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stretchAct(stretchAct), .startEvt(startEvt), .stopEvt(stopEvt),
    .cfgWrA(cfgWrA), .cfgLimitA(cfgLimitA), .cfgIdleA(cfgIdleA),
    .cfgWrB(cfgWrB), .cfgLimitB(cfgLimitB), .enA(enA), .enB(enB),
    .flagClr(flagClr), .timeoutFlag(timeoutFlag)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations as their cycle comes due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (it.at != cyc || timeoutFlag !== it.val) begin
          errors++;
          $display("FAIL %s: cycle %0d flag=%0b expected %0b (due %0d)",
                   it.req, cyc, timeoutFlag, it.val, it.at);
        end
      end
    end
  end

  task automatic expectAt(int at, bit val, string req);
    expQ.push_back('{at, val, req});
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  task automatic writeA(logic [11:0] lim, logic idle);
    cfgLimitA = lim; cfgIdleA = idle; cfgWrA = 1'b1;
    @(negedge clk);
    cfgWrA = 1'b0;
  endtask

  task automatic writeB(logic [11:0] lim);
    cfgLimitB = lim; cfgWrB = 1'b1;
    @(negedge clk);
    cfgWrB = 1'b0;
  endtask

  task automatic clearFlag(string req);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    expectAt(cyc + 1, 1'b0, req);
    drain();
  endtask

  task automatic splitStretch(bit useStop, string req, string frozenReq);
    int c1;
    stretchAct = 1'b1;
    waitCyc(3000);
    stretchAct = 1'b0;
    waitCyc(10);
    if (useStop) stopEvt = 1'b1; else startEvt = 1'b1;
    waitCyc(1);
    stopEvt = 1'b0; startEvt = 1'b0;
    waitCyc(10);
    stretchAct = 1'b1;
    c1 = cyc;
    if (frozenReq != "") expectAt(c1 + 2100, 1'b0, frozenReq);
    expectAt(c1 + 4095, 1'b0, req);
    expectAt(c1 + 4096, 1'b1, req);
    drain();
    stretchAct = 1'b0;
    waitCyc(2);
    clearFlag("R6");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: cycle %0d reached, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    int c1;
    waitCyc(4);
    rstN = 1'b1;
    expectAt(cyc + 1, 1'b0, "R9");
    drain();

    // R9: disabled checkers see low clock and stretching, flag stays 0
    sclIn = 1'b0; stretchAct = 1'b1;
    expectAt(cyc + 2100, 1'b0, "R9");
    drain();
    sclIn = 1'b1; stretchAct = 1'b0;
    waitCyc(4);

    // R1: clock-low timeout with limitA = 0, sticky afterwards (R6)
    writeA(12'd0, 1'b0);
    enA = 1'b1;
    waitCyc(1);
    sclIn = 1'b0; c0 = cyc;
    expectAt(c0 + 2049, 1'b0, "R1");
    expectAt(c0 + 2050, 1'b1, "R1");
    expectAt(c0 + 2150, 1'b1, "R6");
    drain();
    sclIn = 1'b1;
    waitCyc(3);
    clearFlag("R6");

    // R3: a short SCL high pulse restarts the clock-low count
    sclIn = 1'b0; c0 = cyc;
    waitCyc(1000);
    sclIn = 1'b1;
    waitCyc(3);
    sclIn = 1'b0; c1 = cyc;
    expectAt(c0 + 2050, 1'b0, "R3");
    expectAt(c1 + 2049, 1'b0, "R3");
    expectAt(c1 + 2050, 1'b1, "R3");
    drain();
    sclIn = 1'b1;
    waitCyc(3);
    clearFlag("R6");

    // R8: write while enabled is dropped, still clock-low with limit 0
    writeA(12'd5, 1'b1);
    sclIn = 1'b0; c0 = cyc;
    expectAt(c0 + 2049, 1'b0, "R8");
    expectAt(c0 + 2050, 1'b1, "R8");
    drain();
    sclIn = 1'b1;
    waitCyc(3);
    clearFlag("R6");
    enA = 1'b0;
    waitCyc(1);

    // R2: bus-idle timeout, limitA = 3 -> 16 cycles
    writeA(12'd3, 1'b1);
    enA = 1'b1; c0 = cyc;
    expectAt(c0 + 15, 1'b0, "R2");
    expectAt(c0 + 16, 1'b1, "R2");
    drain();
    sdaIn = 1'b0;
    waitCyc(3);
    clearFlag("R6");
    waitCyc(5);
    // R3: SDA low restarted the idle count
    sdaIn = 1'b1; c1 = cyc;
    expectAt(c1 + 17, 1'b0, "R3");
    expectAt(c1 + 18, 1'b1, "R3");
    drain();

    // R7: disabling keeps the flag, and re-enabling starts from zero
    enA = 1'b0;
    expectAt(cyc + 5, 1'b1, "R7");
    drain();
    clearFlag("R7");
    enA = 1'b1;
    waitCyc(10);
    enA = 1'b0;
    waitCyc(1);
    enA = 1'b1; c0 = cyc;
    expectAt(c0 + 15, 1'b0, "R7");
    expectAt(c0 + 16, 1'b1, "R7");
    drain();
    enA = 1'b0;
    waitCyc(1);
    clearFlag("R6");

    // R4: cumulative stretch with limitB = 1 -> 4096 cycles
    writeB(12'd1);
    enB = 1'b1;
    stretchAct = 1'b1;
    waitCyc(3000);
    stretchAct = 1'b0;
    expectAt(cyc + 400, 1'b0, "R4");
    waitCyc(500);
    stretchAct = 1'b1; c1 = cyc;
    expectAt(c1 + 1095, 1'b0, "R4");
    expectAt(c1 + 1096, 1'b1, "R4");
    drain();
    stretchAct = 1'b0;
    waitCyc(2);
    clearFlag("R6");

    // R5: start event clears the accumulated stretch
    splitStretch(1'b0, "R5", "");
    // R5 with stop event, and R8: limitB write during enB dropped
    writeB(12'd0);
    splitStretch(1'b1, "R5", "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule